// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache. It sits between a processor word port and a memory port that moves one whole line per transaction. A processor access gives a byte address. The low bits pick a word inside a four-word line, the middle bits pick one line slot, and the top bits are kept as a tag. A lookup hits only when the chosen slot holds valid data with a matching tag.

On a miss the controller fetches the full line from memory. It installs the line with its tag and then answers the processor. A store that misses fetches the line first in the same way, and then merges the new word into it.

A build-time parameter picks one of two write policies:
- **Write-through:** every store also sends the updated line to memory before the processor gets its acknowledge.
- **Write-back:** stores touch only the cache and mark the line dirty. A dirty line is written out when it is evicted, or when the flush input is pulsed. A flush scans every slot and writes each dirty line back, for example before an I/O transfer.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready`, `flush_done` and `mem_req` are low, and the first access to any address misses and performs a memory line read.
- R2: The address splits into byte bits [1:0] (must be zero), word select [3:2], line index [INDEX_W+3:4] and tag [31:INDEX_W+4]. A read that hits does no memory transaction and raises `cpu_ready` exactly one cycle after the cycle in which it was accepted.
- R3: An access whose index finds a valid line with a different tag misses and replaces that line. A later access to the replaced address misses again.
- R4: A read miss issues one line read at the line-aligned address (bits [3:0] zero). Word n of a line travels in bits [32n+31:32n]. The word selected by address bits [3:2] is returned with `cpu_ready`.
- R5: A store miss first fetches the line. Only the addressed word takes the store data; the other three words keep the values read from memory.
- R6: With `WRITE_BACK`=0, every store (hit or miss) issues exactly one line write carrying the updated line before `cpu_ready`. No line is ever dirty, and a flush writes nothing.
- R7: With `WRITE_BACK`=1, a store that hits does no memory transaction. Memory keeps its old value and the line becomes dirty.
- R8: With `WRITE_BACK`=1, a dirty line chosen for replacement is written to memory at its own address before the new line is read.
- R9: A `flush_req` pulse while idle writes each dirty line exactly once, clears its dirty state and ends with a one-cycle `flush_done`. A second flush with no stores in between writes nothing.
- R10: A request is accepted only while the controller is idle. `cpu_ready` is a one-cycle pulse per request, and `mem_req` stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, sampled while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_ready` |
| flush_req | input | 1 | Start a write-back of all dirty lines |
| flush_done | output | 1 | One-cycle pulse when the flush scan ends |
| mem_req | output | 1 | Memory line transaction request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wline | output | WORD_W*LINE_WORDS | Line data for a write |
| mem_ack | input | 1 | Transaction complete; read data valid |
| mem_rline | input | WORD_W*LINE_WORDS | Line data returned by a read |

## Verification
The bench builds two copies of the cache with `INDEX_W`=3, so there are only eight slots. One copy uses `WRITE_BACK`=1 and the other `WRITE_BACK`=0, and both get the same processor stimulus. With eight slots, addresses 128 bytes apart collide, which makes conflict replacement and dirty eviction easy to provoke. A flush scan then takes only a few cycles. Running both policies side by side lets each store be compared across the two memory models: one memory changes at once and the other changes only on eviction or flush.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache: controller states and the
// reason a line write to memory was started.
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } ctrl_state_t;

    typedef enum logic [1:0] {
        WB_EVICT,
        WB_STORE,
        WB_FLUSH
    } wb_kind_t;
endpackage

// File: rtl/dmc_tag_array.sv
// Per-line valid, dirty and tag storage.
// Assumes one access port: the same index is read and written.
// Valid and dirty bits reset; tags do not need a reset.
module dmc_tag_array #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               install_en,
    input  logic [TAG_W-1:0]   install_tag,
    input  logic               install_dirty,
    input  logic               dirty_set,
    input  logic               dirty_clr,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Status bits: install wins over dirty marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= install_dirty;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end else if (dirty_clr) begin
            dirty_q[idx] <= 1'b0;
        end
    end

    // Tag storage, written only on install.
    always_ff @(posedge clk) begin
        if (install_en) begin
            tag_q[idx] <= install_tag;
        end
    end

    // Combinational read of the indexed entry.
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_line_array.sv
// Line data storage: one full line per index, read combinationally,
// written as a whole line. No reset; contents matter only once valid.
module dmc_line_array #(
    parameter int INDEX_W = 10,
    parameter int LINE_W  = 128
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] idx,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    output logic [LINE_W-1:0]  rd_line
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINE_W-1:0] line_q [LINES];

    // Whole-line write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[idx] <= wr_line;
        end
    end

    assign rd_line = line_q[idx];
endmodule

// File: rtl/dmc_word_merge.sv
// Replaces one word of a line with new data; the other words pass through.
module dmc_word_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [WORD_W*LINE_WORDS-1:0]   base_line,
    input  logic [$clog2(LINE_WORDS)-1:0]  wsel,
    input  logic [WORD_W-1:0]              wdata,
    output logic [WORD_W*LINE_WORDS-1:0]   out_line
);
    localparam int WSEL_W = $clog2(LINE_WORDS);

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign out_line[w*WORD_W +: WORD_W] =
            (wsel == WSEL_W'(w)) ? wdata : base_line[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/dmc_ctrl.sv
// Cache controller. Decodes the processor address, decides hit or miss,
// and walks write-back, refill and respond states one transaction at a time.
// Assumes the memory port holds mem_ack for one cycle per transaction, and
// that the processor presents word-aligned addresses.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int INDEX_W    = 10,
    parameter int WRITE_BACK = 1,
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int OFF_W  = WSEL_W + BYTE_W,
    localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W,
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [WORD_W-1:0]  cpu_rdata,
    input  logic               flush_req,
    output logic               flush_done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rline,
    output logic [INDEX_W-1:0] arr_idx,
    input  logic               rd_valid,
    input  logic               rd_dirty,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic [LINE_W-1:0]  rd_line,
    output logic               tag_install,
    output logic               install_dirty,
    output logic               dirty_set,
    output logic               dirty_clr,
    output logic               line_we,
    output logic [LINE_W-1:0]  line_wdata,
    output logic [LINE_W-1:0]  merge_base,
    output logic [WSEL_W-1:0]  merge_wsel,
    output logic [WORD_W-1:0]  merge_wdata,
    input  logic [LINE_W-1:0]  merged_line
);
    localparam logic [INDEX_W-1:0] LAST_IDX = '1;
    localparam bit WB_MODE = (WRITE_BACK != 0);

    ctrl_state_t        state_q, state_d;
    wb_kind_t           kind_q, kind_d;
    logic [INDEX_W-1:0] cur_idx_q, cur_idx_d;
    logic [TAG_W-1:0]   q_tag_q, q_tag_d;
    logic [WSEL_W-1:0]  q_wsel_q, q_wsel_d;
    logic               q_we_q, q_we_d;
    logic [WORD_W-1:0]  q_wdata_q, q_wdata_d;

    logic [INDEX_W-1:0] req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [WSEL_W-1:0]  req_wsel;
    logic               hit;
    logic [WORD_W-1:0]  words [LINE_WORDS];

    // Address fields of the incoming request.
    assign req_idx  = cpu_addr[OFF_W +: INDEX_W];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_wsel = cpu_addr[BYTE_W +: WSEL_W];
    assign hit      = rd_valid && (rd_tag == req_tag);

    // Storage is indexed by the live address while idle, else by the held index.
    assign arr_idx = (state_q == ST_IDLE) ? req_idx : cur_idx_q;

    // Merge source: refill data from memory, or the cached line on a hit store.
    assign merge_base  = (state_q == ST_REFILL) ? mem_rline : rd_line;
    assign merge_wsel  = (state_q == ST_IDLE) ? req_wsel : q_wsel_q;
    assign merge_wdata = (state_q == ST_IDLE) ? cpu_wdata : q_wdata_q;

    // Split the indexed line into words for the load response.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_rword
        assign words[w] = rd_line[w*WORD_W +: WORD_W];
    end
    assign cpu_rdata = words[q_wsel_q];

    // Memory address: victim tag when writing out, request tag when refilling.
    assign mem_addr = (state_q == ST_WRITEBACK) ? {rd_tag, cur_idx_q, {OFF_W{1'b0}}}
                                                : {q_tag_q, cur_idx_q, {OFF_W{1'b0}}};
    assign mem_req  = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
    assign mem_we   = (state_q == ST_WRITEBACK);

    // Next-state and storage-control decode.
    always_comb begin
        state_d       = state_q;
        kind_d        = kind_q;
        cur_idx_d     = cur_idx_q;
        q_tag_d       = q_tag_q;
        q_wsel_d      = q_wsel_q;
        q_we_d        = q_we_q;
        q_wdata_d     = q_wdata_q;
        cpu_ready     = 1'b0;
        flush_done    = 1'b0;
        tag_install   = 1'b0;
        install_dirty = 1'b0;
        dirty_set     = 1'b0;
        dirty_clr     = 1'b0;
        line_we       = 1'b0;
        line_wdata    = merged_line;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    cur_idx_d = req_idx;
                    q_tag_d   = req_tag;
                    q_wsel_d  = req_wsel;
                    q_we_d    = cpu_we;
                    q_wdata_d = cpu_wdata;
                    if (hit) begin
                        if (cpu_we) begin
                            line_we   = 1'b1;
                            dirty_set = WB_MODE;
                            if (WB_MODE) begin
                                state_d = ST_RESPOND;
                            end else begin
                                kind_d  = WB_STORE;
                                state_d = ST_WRITEBACK;
                            end
                        end else begin
                            state_d = ST_RESPOND;
                        end
                    end else if (WB_MODE && rd_valid && rd_dirty) begin
                        kind_d  = WB_EVICT;
                        state_d = ST_WRITEBACK;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end else if (flush_req) begin
                    cur_idx_d = '0;
                    state_d   = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (rd_valid && rd_dirty) begin
                    kind_d  = WB_FLUSH;
                    state_d = ST_WRITEBACK;
                end else if (cur_idx_q == LAST_IDX) begin
                    flush_done = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    cur_idx_d = cur_idx_q + 1'b1;
                end
            end
            ST_WRITEBACK: begin
                if (mem_ack) begin
                    dirty_clr = 1'b1;
                    unique case (kind_q)
                        WB_EVICT: state_d = ST_REFILL;
                        WB_FLUSH: state_d = ST_FLUSH;
                        default:  state_d = ST_RESPOND;
                    endcase
                end
            end
            ST_REFILL: begin
                if (mem_ack) begin
                    line_we       = 1'b1;
                    line_wdata    = q_we_q ? merged_line : mem_rline;
                    tag_install   = 1'b1;
                    install_dirty = WB_MODE && q_we_q;
                    if (!WB_MODE && q_we_q) begin
                        kind_d  = WB_STORE;
                        state_d = ST_WRITEBACK;
                    end else begin
                        state_d = ST_RESPOND;
                    end
                end
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= WB_EVICT;
            cur_idx_q <= '0;
            q_tag_q   <= '0;
            q_wsel_q  <= '0;
            q_we_q    <= 1'b0;
            q_wdata_q <= '0;
        end else begin
            state_q   <= state_d;
            kind_q    <= kind_d;
            cur_idx_q <= cur_idx_d;
            q_tag_q   <= q_tag_d;
            q_wsel_q  <= q_wsel_d;
            q_we_q    <= q_we_d;
            q_wdata_q <= q_wdata_d;
        end
    end

    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BYTE_W-1:0] == '0));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4
    refill_respond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_REFILL) && mem_ack && !q_we_q) |=> cpu_ready);

    // R8
    clean_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL) |-> !(rd_valid && rd_dirty));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WRITEBACK) && (kind_q == WB_FLUSH) && mem_ack)
            |=> ((state_q == ST_FLUSH) && !rd_dirty));

    // R6
    wt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!WB_MODE && rd_valid) |-> !rd_dirty);
endmodule

// File: rtl/dm_cache.sv
// Direct-mapped data cache top: ties the controller to tag storage, line
// storage and the word merge. Write policy is fixed by WRITE_BACK
// (1 = write-back with dirty lines, 0 = write-through).
module dm_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int INDEX_W    = 10,
    parameter int WRITE_BACK = 1,
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int OFF_W  = WSEL_W + $clog2(WORD_W / 8),
    localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W,
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wline,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rline
);
    logic [INDEX_W-1:0] arr_idx;
    logic               rd_valid, rd_dirty;
    logic [TAG_W-1:0]   rd_tag;
    logic [LINE_W-1:0]  rd_line;
    logic               tag_install, install_dirty, dirty_set, dirty_clr;
    logic               line_we;
    logic [LINE_W-1:0]  line_wdata, merge_base, merged_line;
    logic [WSEL_W-1:0]  merge_wsel;
    logic [WORD_W-1:0]  merge_wdata;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
        .INDEX_W(INDEX_W), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .flush_done(flush_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rline(mem_rline),
        .arr_idx(arr_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_line(rd_line),
        .tag_install(tag_install), .install_dirty(install_dirty),
        .dirty_set(dirty_set), .dirty_clr(dirty_clr),
        .line_we(line_we), .line_wdata(line_wdata),
        .merge_base(merge_base), .merge_wsel(merge_wsel), .merge_wdata(merge_wdata),
        .merged_line(merged_line)
    );

    dmc_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx),
        .install_en(tag_install), .install_tag(mem_addr[ADDR_W-1 -: TAG_W]),
        .install_dirty(install_dirty), .dirty_set(dirty_set), .dirty_clr(dirty_clr),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag)
    );

    dmc_line_array #(.INDEX_W(INDEX_W), .LINE_W(LINE_W)) u_lines (
        .clk(clk), .idx(arr_idx), .wr_en(line_we), .wr_line(line_wdata),
        .rd_line(rd_line)
    );

    dmc_word_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_merge (
        .base_line(merge_base), .wsel(merge_wsel), .wdata(merge_wdata),
        .out_line(merged_line)
    );

    // A line write always carries the currently indexed cached line.
    assign mem_wline = rd_line;
endmodule

// File: tb/dm_cache_tb.sv
// Scoreboard bench: one write-back and one write-through cache see the same
// processor stimulus, each with its own line-wide memory model.
module dm_cache_tb;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, flush_req = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;

    logic         rdy_wb, fd_wb, mreq_wb, mwe_wb, mack_wb;
    logic [31:0]  rdata_wb, maddr_wb;
    logic [127:0] mwline_wb, mrline_wb;
    logic         rdy_wt, fd_wt, mreq_wt, mwe_wt, mack_wt;
    logic [31:0]  rdata_wt, maddr_wt;
    logic [127:0] mwline_wt, mrline_wt;

    always #5 clk = ~clk;

    dm_cache #(.INDEX_W(IW), .WRITE_BACK(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(rdy_wb),
        .cpu_rdata(rdata_wb), .flush_req(flush_req), .flush_done(fd_wb),
        .mem_req(mreq_wb), .mem_we(mwe_wb), .mem_addr(maddr_wb),
        .mem_wline(mwline_wb), .mem_ack(mack_wb), .mem_rline(mrline_wb));

    dm_cache #(.INDEX_W(IW), .WRITE_BACK(0)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(rdy_wt),
        .cpu_rdata(rdata_wt), .flush_req(flush_req), .flush_done(fd_wt),
        .mem_req(mreq_wt), .mem_we(mwe_wt), .mem_addr(maddr_wt),
        .mem_wline(mwline_wt), .mem_ack(mack_wt), .mem_rline(mrline_wt));

    int n_checks = 0, n_errors = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Initial memory content: each word holds a pattern of its own address.
    function automatic logic [127:0] init_line(int unsigned ln);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = 32'hC0DE_0000 ^ (ln*16 + w*4);
        return l;
    endfunction

    logic [127:0] mem_wb [int unsigned];
    logic [127:0] mem_wt [int unsigned];
    logic [31:0]  gold   [int unsigned];
    int rd_wb = 0, wr_wb = 0, rd_wt = 0, wr_wt = 0;
    int cnt_wb = 0, cnt_wt = 0;
    int unsigned ln_wb, ln_wt;

    function automatic logic [31:0] pattern(logic [31:0] a);
        return 32'hC0DE_0000 ^ a;
    endfunction

    function automatic logic [31:0] gword(logic [31:0] a);
        return gold.exists(a) ? gold[a] : pattern(a);
    endfunction

    function automatic logic [31:0] memword_wb(logic [31:0] a);
        logic [127:0] l;
        l = mem_wb.exists(a >> 4) ? mem_wb[a >> 4] : init_line(a >> 4);
        return l[a[3:2]*32 +: 32];
    endfunction

    function automatic logic [31:0] memword_wt(logic [31:0] a);
        logic [127:0] l;
        l = mem_wt.exists(a >> 4) ? mem_wt[a >> 4] : init_line(a >> 4);
        return l[a[3:2]*32 +: 32];
    endfunction

    // Write-back side memory: acknowledges after three cycles of request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mack_wb <= 1'b0; cnt_wb = 0;
        end else begin
            mack_wb <= 1'b0;
            if (mreq_wb && !mack_wb) begin
                if (cnt_wb == 2) begin
                    cnt_wb = 0;
                    mack_wb <= 1'b1;
                    ln_wb = maddr_wb >> 4;
                    if (mwe_wb) begin mem_wb[ln_wb] = mwline_wb; wr_wb++; end
                    else begin
                        mrline_wb <= mem_wb.exists(ln_wb) ? mem_wb[ln_wb] : init_line(ln_wb);
                        rd_wb++;
                    end
                end else cnt_wb++;
            end
        end
    end

    // Write-through side memory, same timing.
    always @(posedge clk) begin
        if (!rst_n) begin
            mack_wt <= 1'b0; cnt_wt = 0;
        end else begin
            mack_wt <= 1'b0;
            if (mreq_wt && !mack_wt) begin
                if (cnt_wt == 2) begin
                    cnt_wt = 0;
                    mack_wt <= 1'b1;
                    ln_wt = maddr_wt >> 4;
                    if (mwe_wt) begin mem_wt[ln_wt] = mwline_wt; wr_wt++; end
                    else begin
                        mrline_wt <= mem_wt.exists(ln_wt) ? mem_wt[ln_wt] : init_line(ln_wt);
                        rd_wt++;
                    end
                end else cnt_wt++;
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q_wb[$];
    item_t q_wt[$];
    int issued = 0, resp_wb = 0, resp_wt = 0, issue_cyc = 0, lat_wb = 0;
    bit fdone_wb = 0, fdone_wt = 0;

    // Monitor: pops the expected item for each response, compares load data.
    always @(negedge clk) begin
        item_t it;
        if (rst_n) begin
            if (rdy_wb) begin
                lat_wb = cyc - issue_cyc;
                if (q_wb.size() == 0) check(0, "R10", "wb unexpected ready", 32'd1, 32'd0);
                else begin
                    it = q_wb.pop_front();
                    if (it.is_rd) check(rdata_wb === it.exp, it.req, "wb load data", rdata_wb, it.exp);
                end
                resp_wb++;
            end
            if (rdy_wt) begin
                if (q_wt.size() == 0) check(0, "R10", "wt unexpected ready", 32'd1, 32'd0);
                else begin
                    it = q_wt.pop_front();
                    if (it.is_rd) check(rdata_wt === it.exp, it.req, "wt load data", rdata_wt, it.exp);
                end
                resp_wt++;
            end
            if (fd_wb) fdone_wb = 1;
            if (fd_wt) fdone_wt = 1;
        end
    end

    // Driver: records expectation, pulses one request, waits for both caches.
    task automatic cpu_op(bit we, logic [31:0] addr, logic [31:0] wdata, string req);
        item_t it;
        it.is_rd = !we;
        it.exp   = we ? 32'h0 : gword(addr);
        it.req   = req;
        if (we) gold[addr] = wdata;
        q_wb.push_back(it);
        q_wt.push_back(it);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        issue_cyc = cyc;
        issued++;
        @(negedge clk);
        cpu_req = 1'b0;
        while (resp_wb < issued || resp_wt < issued) @(negedge clk);
        @(negedge clk);
        // R10: ready is a single-cycle pulse
        check(!rdy_wb && !rdy_wt, "R10", "ready after response", {rdy_wb, rdy_wt}, 32'd0);
    endtask

    task automatic do_flush();
        fdone_wb = 0; fdone_wt = 0;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        while (!fdone_wb || !fdone_wt) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int r0, w0, t0, tw0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(!rdy_wb && !rdy_wt && !fd_wb && !fd_wt, "R1", "ready/done after reset", 32'd0, 32'd0);
        check(!mreq_wb && !mreq_wt, "R1", "mem_req after reset", {mreq_wb, mreq_wt}, 32'd0);

        // R1 R4: first access misses and fetches a line, word 1 returned
        cpu_op(0, 32'h0000_0014, 0, "R4");
        check(rd_wb == 1 && rd_wt == 1, "R1", "refill on first access", rd_wb, 1);

        // R2: same line, other word hits with one-cycle latency
        cpu_op(0, 32'h0000_001C, 0, "R2");
        check(rd_wb == 1 && rd_wt == 1, "R2", "no refill on hit", rd_wb, 1);
        check(lat_wb == 1, "R2", "hit latency", lat_wb, 1);

        // R3: conflicting tag replaces line; original then misses again
        cpu_op(0, 32'h0000_0094, 0, "R3");
        check(rd_wb == 2, "R3", "conflict refill", rd_wb, 2);
        cpu_op(0, 32'h0000_0014, 0, "R3");
        check(rd_wb == 3 && rd_wt == 3, "R3", "re-miss after replace", rd_wb, 3);

        // R5: store miss fetches first, other words keep memory values
        cpu_op(1, 32'h0000_0208, 32'h1111_2222, "R5");
        check(rd_wb == 4 && rd_wt == 4, "R5", "store miss refill", rd_wb, 4);
        cpu_op(0, 32'h0000_020C, 0, "R5");
        cpu_op(0, 32'h0000_0200, 0, "R5");
        cpu_op(0, 32'h0000_0208, 0, "R5");
        // R6: write-through memory updated; R7: write-back memory untouched
        check(memword_wt(32'h208) == 32'h1111_2222, "R6", "wt memory word", memword_wt(32'h208), 32'h1111_2222);
        check(wr_wt == 1, "R6", "wt line writes", wr_wt, 1);
        check(memword_wb(32'h208) == pattern(32'h208), "R7", "wb memory stale", memword_wb(32'h208), pattern(32'h208));
        check(wr_wb == 0, "R7", "wb line writes", wr_wb, 0);

        // R7 R6: store hit
        r0 = rd_wb;
        cpu_op(1, 32'h0000_0014, 32'hAAAA_5555, "R7");
        check(rd_wb == r0 && wr_wb == 0, "R7", "wb store hit quiet", wr_wb, 0);
        check(lat_wb == 1, "R7", "wb store hit latency", lat_wb, 1);
        check(wr_wt == 2, "R6", "wt store hit writes", wr_wt, 2);
        check(memword_wt(32'h14) == 32'hAAAA_5555, "R6", "wt hit memory", memword_wt(32'h14), 32'hAAAA_5555);

        // R8: dirty victim written back before refill
        tw0 = wr_wt;
        cpu_op(0, 32'h0000_0094, 0, "R8");
        check(wr_wb == 1, "R8", "eviction write", wr_wb, 1);
        check(memword_wb(32'h14) == 32'hAAAA_5555, "R8", "evicted word", memword_wb(32'h14), 32'hAAAA_5555);
        check(memword_wb(32'h10) == pattern(32'h10), "R8", "evicted neighbour", memword_wb(32'h10), pattern(32'h10));
        check(wr_wt == tw0, "R6", "wt no eviction write", wr_wt, tw0);

        // R9: flush writes each dirty line once
        cpu_op(1, 32'h0000_0030, 32'h3333_0000, "R9");
        cpu_op(1, 32'h0000_0044, 32'h4444_0000, "R9");
        cpu_op(1, 32'h0000_0034, 32'h3333_0004, "R9");
        w0 = wr_wb; tw0 = wr_wt;
        do_flush();
        check(wr_wb == w0 + 3, "R9", "wb flush writes", wr_wb, w0 + 3);
        check(wr_wt == tw0, "R6", "wt flush writes", wr_wt, tw0);
        check(memword_wb(32'h208) == 32'h1111_2222, "R9", "flushed 0x208", memword_wb(32'h208), 32'h1111_2222);
        check(memword_wb(32'h30) == 32'h3333_0000, "R9", "flushed 0x30", memword_wb(32'h30), 32'h3333_0000);
        check(memword_wb(32'h34) == 32'h3333_0004, "R9", "flushed 0x34", memword_wb(32'h34), 32'h3333_0004);
        check(memword_wb(32'h44) == 32'h4444_0000, "R9", "flushed 0x44", memword_wb(32'h44), 32'h4444_0000);
        w0 = wr_wb;
        do_flush();
        check(wr_wb == w0, "R9", "second flush quiet", wr_wb, w0);

        // R9: lines stay valid after flush, load hits
        r0 = rd_wb; t0 = rd_wt;
        cpu_op(0, 32'h0000_0030, 0, "R9");
        check(rd_wb == r0 && rd_wt == t0, "R9", "hit after flush", rd_wb, r0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule